// File: doc/BRIEF.md
# OTP Program Pulse Sequencer

This block times one programming pulse for a one-time-programmable bit array. Software writes the target bit address, the data byte and six timing counts through a small write-only register port. It then latches the data into the array by raising the latch strobe, pulsing the active-low write strobe and dropping the latch strobe again. Writing the start bit launches a hardware walk through five timed phases. In the first phase only program-enable is high. Next the charge-pump enable rises. The sequencer then pulls the write strobe low for a set width and releases it. After that the pump turns off, and finally program-enable falls on its own. Software polls the busy output to learn that the pulse is over.

The start bit only takes effect when the unlock gate is open. The gate opens when two key registers hold their key words and the active-low chip-enable register is 0. A start request made while the gate is closed does nothing except set a sticky error flag. A second timer handles reads. After read-enable is raised, or after the address changes while reading, read data is marked valid only once a programmable number of cycles has passed. The array reset pin and the strobe pins follow their registers directly, so software times the reset pulse and the latch edges.

Top module: `otp_pulse_seq`

## Requirements
- R1: After reset: otp_pgm, otp_pump, busy, err, otp_dle, otp_rden and rd_valid are 0; otp_web_n, otp_rst_n and otp_ce_n are 1; rd_data is 0.
- R2: A register write shows up on its pin one clock after the write edge. The selects are: 0 address, 1 data byte, 2 latch strobe (bit 0), 3 write-strobe level (bit 0, 1 = released), 4 array reset level (bit 0), 5 chip-enable level (bit 0, 0 = enabled). Select 9 is read-enable (bit 0).
- R3: A start write (select 8, bit 0 = 1) is accepted only if three things hold. The last write to select 6 was 0xEBCF0000. The last write to select 7 was 0xEBCF1111. The chip-enable register is 0.
- R4: A start write made while the gate is closed leaves otp_pgm and busy at 0 and sets err. err then stays 1 until reset.
- R5: An accepted pulse runs in five phases, in order, with phase counts N0..N4 (selects 10..14). Phase 0 has only otp_pgm high. otp_pump is high through phases 1 to 3. otp_web_n is held low in phase 2, whatever the write-strobe register holds. Phase 4 has only otp_pgm high.
- R6: Each phase lasts exactly Ni clock cycles, for Ni from 1 to 2047. otp_pgm is high for N0+N1+N2+N3+N4 cycles, starting one clock after the accepted start write.
- R7: A phase count of 0 gives a phase of one cycle.
- R8: At the end of phase 4, otp_pgm and busy return to 0 without any software action. busy equals otp_pgm throughout.
- R9: While busy, writes to selects 10..14 and start writes are ignored. The running pulse is neither restarted nor lengthened, and the stored phase counts stay unchanged for later pulses.
- R10: Select 15 holds the read-wait count D. Raising read-enable, or writing the address while read-enable is 1, drops rd_valid. rd_valid rises again max(D,1) cycles after that write edge. rd_valid is 0 while read-enable is 0. rd_data shows the array byte when rd_valid is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | BUS_W (32) | Write data |
| otp_q | input | DATA_W (8) | Byte returned by the array |
| otp_addr | output | ADDR_W (12) | Bit address to the array |
| otp_din | output | DATA_W (8) | Data byte to the array |
| otp_dle | output | 1 | Data latch strobe |
| otp_web_n | output | 1 | Active-low write strobe |
| otp_rst_n | output | 1 | Active-low array reset |
| otp_ce_n | output | 1 | Active-low chip enable |
| otp_pgm | output | 1 | Program-enable, self-clearing |
| otp_pump | output | 1 | Charge-pump enable |
| otp_rden | output | 1 | Array read enable |
| rd_data | output | DATA_W (8) | Read byte, qualified by rd_valid |
| rd_valid | output | 1 | Read data valid |
| busy | output | 1 | Pulse in progress |
| err | output | 1 | Sticky locked-start error |

## Verification
Register pins and the start of program-enable change one clock after the write edge. The bench drives every write on a falling edge and samples on the next falling edge, so its index-zero sample already lies inside phase 0. A monitor counts falling-edge samples while otp_pgm is high. It records the sample at which the pump rises and the one at which the write strobe falls. These are compared with the sums of phase counts that the bench computes. rd_valid is due max(D,1) edges after the read-enable or address write, so the bench counts falling edges from the write's own sample and expects the first valid sample at exactly that index.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
   localparam int NUM_PH = 5;

   typedef enum logic [2:0] {
      PS_IDLE  = 3'd0,
      PS_LEAD  = 3'd1,
      PS_RAMP  = 3'd2,
      PS_STRB  = 3'd3,
      PS_DRAIN = 3'd4,
      PS_TAIL  = 3'd5
   } ph_state_e;

   localparam logic [3:0] SEL_ADDR  = 4'd0;
   localparam logic [3:0] SEL_DATA  = 4'd1;
   localparam logic [3:0] SEL_LATCH = 4'd2;
   localparam logic [3:0] SEL_STRB  = 4'd3;
   localparam logic [3:0] SEL_ARST  = 4'd4;
   localparam logic [3:0] SEL_CE    = 4'd5;
   localparam logic [3:0] SEL_KEYA  = 4'd6;
   localparam logic [3:0] SEL_KEYB  = 4'd7;
   localparam logic [3:0] SEL_PROG  = 4'd8;
   localparam logic [3:0] SEL_RDEN  = 4'd9;
   localparam logic [3:0] SEL_PH0   = 4'd10;
   localparam logic [3:0] SEL_RDW   = 4'd15;
endpackage

// File: rtl/otp_seq_regs.sv
module otp_seq_regs
   import otp_seq_pkg::*;
#(
   parameter int          ADDR_W = 12,
   parameter int          DATA_W = 8,
   parameter int          PH_W   = 11,
   parameter int          DO_W   = 9,
   parameter int          BUS_W  = 32,
   parameter logic [31:0] KEY_A  = 32'hEBCF0000,
   parameter logic [31:0] KEY_B  = 32'hEBCF1111
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [3:0]                     sel,
   input  logic [BUS_W-1:0]               wdata,
   input  logic                           busy,
   output logic [ADDR_W-1:0]              addr,
   output logic [DATA_W-1:0]              din,
   output logic                           dle,
   output logic                           web,
   output logic                           arst_n,
   output logic                           ce_n,
   output logic                           rden,
   output logic [NUM_PH-1:0][PH_W-1:0]    ph_cfg,
   output logic [DO_W-1:0]                rdw_cfg,
   output logic                           start,
   output logic                           gate,
   output logic                           err,
   output logic                           rd_restart
);
   localparam logic [BUS_W-1:0] KA = BUS_W'(KEY_A);
   localparam logic [BUS_W-1:0] KB = BUS_W'(KEY_B);

   logic key_a_ok, key_b_ok;
   logic prog_hit;

   assign gate       = key_a_ok & key_b_ok & ~ce_n;
   assign prog_hit   = we && (sel == SEL_PROG) && wdata[0] && !busy;
   assign start      = prog_hit && gate;
   assign rd_restart = we && (((sel == SEL_RDEN) && wdata[0]) ||
                              ((sel == SEL_ADDR) && rden));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr     <= '0;
         din      <= '0;
         dle      <= 1'b0;
         web      <= 1'b1;
         arst_n   <= 1'b1;
         ce_n     <= 1'b1;
         rden     <= 1'b0;
         key_a_ok <= 1'b0;
         key_b_ok <= 1'b0;
         err      <= 1'b0;
         rdw_cfg  <= DO_W'(1);
         for (int i = 0; i < NUM_PH; i++) ph_cfg[i] <= PH_W'(1);
      end else begin
         if (we) begin
            case (sel)
               SEL_ADDR:  addr     <= wdata[ADDR_W-1:0];
               SEL_DATA:  din      <= wdata[DATA_W-1:0];
               SEL_LATCH: dle      <= wdata[0];
               SEL_STRB:  web      <= wdata[0];
               SEL_ARST:  arst_n   <= wdata[0];
               SEL_CE:    ce_n     <= wdata[0];
               SEL_KEYA:  key_a_ok <= (wdata == KA);
               SEL_KEYB:  key_b_ok <= (wdata == KB);
               SEL_RDEN:  rden     <= wdata[0];
               SEL_RDW:   rdw_cfg  <= wdata[DO_W-1:0];
               default: ;
            endcase
         end
         for (int i = 0; i < NUM_PH; i++) begin
            if (we && !busy && (sel == 4'(int'(SEL_PH0) + i)))
               ph_cfg[i] <= wdata[PH_W-1:0];
         end
         if (prog_hit && !gate) err <= 1'b1;
      end
   end
endmodule

// File: rtl/otp_seq_phase.sv
module otp_seq_phase
   import otp_seq_pkg::*;
#(
   parameter int PH_W = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [NUM_PH-1:0][PH_W-1:0] ph_cfg,
   output logic                        pgm,
   output logic                        pump,
   output logic                        strobe,
   output logic                        busy
);
   logic [NUM_PH-1:0][PH_W-1:0] lim;
   logic [PH_W-1:0]             cnt, cur_lim;
   ph_state_e                   state, nxt;

   for (genvar g = 0; g < NUM_PH; g++) begin : g_lim
      assign lim[g] = (ph_cfg[g] == '0) ? '0 : ph_cfg[g] - PH_W'(1);
   end

   always_comb begin
      cur_lim = '0;
      nxt     = PS_IDLE;
      case (state)
         PS_LEAD:  begin cur_lim = lim[0]; nxt = PS_RAMP;  end
         PS_RAMP:  begin cur_lim = lim[1]; nxt = PS_STRB;  end
         PS_STRB:  begin cur_lim = lim[2]; nxt = PS_DRAIN; end
         PS_DRAIN: begin cur_lim = lim[3]; nxt = PS_TAIL;  end
         PS_TAIL:  begin cur_lim = lim[4]; nxt = PS_IDLE;  end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_IDLE;
         cnt   <= '0;
      end else if (state == PS_IDLE) begin
         if (start) begin
            state <= PS_LEAD;
            cnt   <= '0;
         end
      end else if (cnt == cur_lim) begin
         state <= nxt;
         cnt   <= '0;
      end else begin
         cnt <= cnt + PH_W'(1);
      end
   end

   assign pgm    = (state != PS_IDLE);
   assign pump   = (state == PS_RAMP) || (state == PS_STRB) || (state == PS_DRAIN);
   assign strobe = (state == PS_STRB);
   assign busy   = pgm;
endmodule

// File: rtl/otp_seq_rdwait.sv
module otp_seq_rdwait #(
   parameter int DO_W = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rden,
   input  logic            restart,
   input  logic [DO_W-1:0] wait_cfg,
   output logic            valid
);
   logic [DO_W-1:0] cnt, lim;
   logic            waiting, ready;

   assign lim = (wait_cfg == '0) ? '0 : wait_cfg - DO_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         waiting <= 1'b0;
         ready   <= 1'b0;
      end else if (restart) begin
         cnt     <= '0;
         waiting <= 1'b1;
         ready   <= 1'b0;
      end else if (!rden) begin
         waiting <= 1'b0;
         ready   <= 1'b0;
      end else if (waiting) begin
         if (cnt == lim) begin
            waiting <= 1'b0;
            ready   <= 1'b1;
         end else begin
            cnt <= cnt + DO_W'(1);
         end
      end
   end

   assign valid = ready & rden;
endmodule

// File: rtl/otp_pulse_seq.sv
module otp_pulse_seq
   import otp_seq_pkg::*;
#(
   parameter int          ADDR_W = 12,
   parameter int          DATA_W = 8,
   parameter int          PH_W   = 11,
   parameter int          DO_W   = 9,
   parameter int          BUS_W  = 32,
   parameter logic [31:0] KEY_A  = 32'hEBCF0000,
   parameter logic [31:0] KEY_B  = 32'hEBCF1111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_sel,
   input  logic [BUS_W-1:0]  reg_wdata,
   input  logic [DATA_W-1:0] otp_q,
   output logic [ADDR_W-1:0] otp_addr,
   output logic [DATA_W-1:0] otp_din,
   output logic              otp_dle,
   output logic              otp_web_n,
   output logic              otp_rst_n,
   output logic              otp_ce_n,
   output logic              otp_pgm,
   output logic              otp_pump,
   output logic              otp_rden,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              err
);
   if (PH_W < 2 || PH_W > 16) begin : g_bad_ph
      $error("PH_W out of range");
   end
   if (DO_W < 1 || DO_W > 16) begin : g_bad_do
      $error("DO_W out of range");
   end
   if (BUS_W < 32 || ADDR_W > BUS_W || DATA_W > BUS_W || PH_W > BUS_W) begin : g_bad_bus
      $error("BUS_W too narrow");
   end

   logic [NUM_PH-1:0][PH_W-1:0] ph_cfg;
   logic [DO_W-1:0]             rdw_cfg;
   logic                        sw_web, seq_start, unlock_open, rd_restart, seq_strobe;

   otp_seq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PH_W(PH_W), .DO_W(DO_W),
      .BUS_W(BUS_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
      .busy(busy), .addr(otp_addr), .din(otp_din), .dle(otp_dle), .web(sw_web),
      .arst_n(otp_rst_n), .ce_n(otp_ce_n), .rden(otp_rden), .ph_cfg(ph_cfg),
      .rdw_cfg(rdw_cfg), .start(seq_start), .gate(unlock_open), .err(err),
      .rd_restart(rd_restart)
   );

   otp_seq_phase #(.PH_W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .start(seq_start), .ph_cfg(ph_cfg),
      .pgm(otp_pgm), .pump(otp_pump), .strobe(seq_strobe), .busy(busy)
   );

   otp_seq_rdwait #(.DO_W(DO_W)) u_rdw (
      .clk(clk), .rst_n(rst_n), .rden(otp_rden), .restart(rd_restart),
      .wait_cfg(rdw_cfg), .valid(rd_valid)
   );

   assign otp_web_n = sw_web & ~seq_strobe;
   assign rd_data   = rd_valid ? otp_q : '0;
endmodule

// File: rtl/otp_seq_chk.sv
module otp_seq_chk
   import otp_seq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       reg_we,
   input logic [3:0] reg_sel,
   input logic       wbit,
   input logic       busy,
   input logic       gate,
   input logic       otp_pgm,
   input logic       otp_pump,
   input logic       otp_web_n,
   input logic       otp_rden,
   input logic       rd_valid,
   input logic       err
);
   AST_PUMP_INSIDE_PGM: assert property (@(posedge clk) disable iff (!rst_n)
      otp_pump |-> otp_pgm); // R5
   AST_STROBE_INSIDE_PUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (otp_pgm && !otp_web_n) |-> otp_pump); // R5
   AST_PUMP_AFTER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(otp_pump) |-> $past(otp_pgm)); // R5
   AST_LOCKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == SEL_PROG && wbit && !busy && !gate) |=> !busy); // R3
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err); // R4
   AST_BUSY_TRACKS_PGM: assert property (@(posedge clk) disable iff (!rst_n)
      busy == otp_pgm); // R8
   AST_VALID_NEEDS_RDEN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> otp_rden); // R10
endmodule

bind otp_pulse_seq otp_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
   .wbit(reg_wdata[0]), .busy(busy), .gate(unlock_open), .otp_pgm(otp_pgm),
   .otp_pump(otp_pump), .otp_web_n(otp_web_n), .otp_rden(otp_rden),
   .rd_valid(rd_valid), .err(err)
);

// File: tb/sim_otp_pulse_seq.sv
`timescale 1ns/1ps
module sim_otp_pulse_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [7:0]  otp_q;
   logic [11:0] otp_addr;
   logic [7:0]  otp_din, rd_data;
   logic        otp_dle, otp_web_n, otp_rst_n, otp_ce_n, otp_pgm, otp_pump;
   logic        otp_rden, rd_valid, busy, err;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   otp_pulse_seq u0 (.*);

   // behavioural fuse array
   logic [255:0] fuse = '0;
   logic         latch_bit = 1'b0;
   always @(posedge otp_web_n) if (otp_dle === 1'b1) latch_bit <= otp_din[0];
   always @(negedge otp_web_n) if (otp_pgm === 1'b1 && latch_bit) fuse[otp_addr[7:0]] <= 1'b1;
   assign otp_q = fuse[{otp_addr[7:3], 3'b000} +: 8];

   // pulse shape monitor, sampled on falling edges
   int pgm_len, pump_first, pump_len, web_first, web_len;
   always @(negedge clk) begin
      if (otp_pgm === 1'b1) begin
         if (otp_pump) begin
            if (pump_len == 0) pump_first = pgm_len;
            pump_len++;
         end
         if (!otp_web_n) begin
            if (web_len == 0) web_first = pgm_len;
            web_len++;
         end
         pgm_len++;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] s, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic clr_mon();
      pgm_len = 0; pump_first = -1; pump_len = 0; web_first = -1; web_len = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000 && otp_pgm; i++) @(negedge clk);
   endtask

   task automatic set_ph(int a, int b, int c, int d, int e);
      wr(4'd10, a); wr(4'd11, b); wr(4'd12, c); wr(4'd13, d); wr(4'd14, e);
   endtask

   function automatic int m(int v); return (v == 0) ? 1 : v; endfunction

   task automatic run_pulse(string tag, int a, int b, int c, int d, int e);
      clr_mon();
      wr(4'd8, 1);
      chk({tag, " busy at start"}, {otp_pgm, busy}, 2'b11);
      wait_idle();
      chk({tag, " pgm length"}, pgm_len, m(a)+m(b)+m(c)+m(d)+m(e));
      chk({tag, " pump offset"}, pump_first, m(a));
      chk({tag, " pump length"}, pump_len, m(b)+m(c)+m(d));
      chk({tag, " strobe offset"}, web_first, m(a)+m(b));
      chk({tag, " strobe length"}, web_len, m(c));
      chk({tag, " R8 self clear"}, {otp_pgm, busy, otp_pump, otp_web_n}, 4'b0001);
   endtask

   task automatic t_reset();
      chk("R1 reset lows", {otp_pgm, otp_pump, busy, err, otp_dle, otp_rden, rd_valid}, 7'b0);
      chk("R1 reset highs", {otp_web_n, otp_rst_n, otp_ce_n}, 3'b111);
      chk("R1 rd_data", rd_data, 8'h00);
   endtask

   task automatic t_pins();
      wr(4'd0, 32'h5);   chk("R2 address pin", otp_addr, 12'h5);
      wr(4'd1, 32'h1);   chk("R2 data pin", otp_din, 8'h1);
      wr(4'd2, 32'h1);   chk("R2 latch pin", otp_dle, 1'b1);
      wr(4'd3, 32'h0);   chk("R2 strobe pin low", otp_web_n, 1'b0);
      wr(4'd3, 32'h1);   chk("R2 strobe pin high", otp_web_n, 1'b1);
      wr(4'd2, 32'h0);   chk("R2 latch pin low", otp_dle, 1'b0);
      wr(4'd4, 32'h0);   chk("R2 reset pin low", otp_rst_n, 1'b0);
      wr(4'd4, 32'h1);   chk("R2 reset pin high", otp_rst_n, 1'b1);
   endtask

   task automatic t_locked();
      wr(4'd8, 1);
      chk("R4 locked start ignored", {otp_pgm, busy}, 2'b00);
      chk("R4 error set", err, 1'b1);
      wr(4'd6, 32'hEBCF0000); wr(4'd7, 32'hEBCF1111);
      wr(4'd8, 1);
      chk("R3 chip enable high keeps gate shut", otp_pgm, 1'b0);
      wr(4'd5, 0); wr(4'd7, 32'hEBCF1110);
      wr(4'd8, 1);
      chk("R3 wrong second key keeps gate shut", otp_pgm, 1'b0);
      chk("R4 error sticky", err, 1'b1);
      wr(4'd7, 32'hEBCF1111);
      chk("R2 chip enable pin", otp_ce_n, 1'b0);
   endtask

   task automatic t_pulse();
      set_ph(3, 4, 5, 2, 1);
      run_pulse("R3 R5 R6 pulse", 3, 4, 5, 2, 1);
      chk("R4 error still set", err, 1'b1);
   endtask

   task automatic t_zero();
      set_ph(0, 0, 0, 0, 0);
      run_pulse("R7 zero counts", 0, 0, 0, 0, 0);
   endtask

   task automatic t_busy();
      set_ph(2, 2, 2, 2, 2);
      clr_mon();
      wr(4'd8, 1);
      wr(4'd12, 9);
      wr(4'd8, 1);
      wait_idle();
      chk("R9 pulse not extended", pgm_len, 10);
      chk("R9 strobe width unchanged", web_len, 2);
      run_pulse("R9 counts kept", 2, 2, 2, 2, 2);
   endtask

   task automatic rd_wait(string tag, int exp_k);
      int k = 0;
      chk({tag, " valid dropped"}, rd_valid, 1'b0);
      while (!rd_valid && k < 100) begin @(negedge clk); k++; end
      chk({tag, " wait cycles"}, k, exp_k);
   endtask

   task automatic t_read();
      wr(4'd15, 6);
      wr(4'd0, 0);
      chk("R10 idle valid", rd_valid, 1'b0);
      wr(4'd9, 1);
      rd_wait("R10 enable", 6);
      chk("R10 programmed byte", rd_data, 8'h20);
      wr(4'd15, 0);
      wr(4'd0, 8);
      rd_wait("R10 zero count", 1);
      chk("R10 blank byte", rd_data, 8'h00);
      wr(4'd9, 0);
      chk("R10 disable", {rd_valid, rd_data}, 9'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pins();
      wr(4'd1, 32'h1); wr(4'd2, 1); wr(4'd3, 0); wr(4'd3, 1); wr(4'd2, 0);
      t_locked();
      t_pulse();
      t_zero();
      t_busy();
      t_read();
      finish_run();
   end
endmodule